// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Engine

This block is the device-addressing layer of a single-wire slave. It sits above a time-slot engine, which measures the reset, presence and bit-slot timing on the wire. Each finished slot reaches this block as a strobe carrying the sampled bit. A separate pulse reports that the time-slot engine saw a bus reset. After every reset the engine collects an 8-bit ROM command and serves it against a 64-bit device identity.

Reading the identity and matching it against a code from the master both select the device, and so does skipping addressing. The two search flavours run bit-by-bit arbitration. In that arbitration the slave offers each identity bit and then its complement, and stays in only while the master's chosen bit agrees with its own. Once the device is selected, the next byte is taken as a function command. A recognised code is handed to a downstream dispatcher with a one-cycle strobe.

When the engine wants to drive the wire in the coming slot, it raises `tx_en` and places the bit on `tx_bit`. The time-slot engine then uses that slot as a read slot.

Top module: `owr_rom_engine`

## Requirements
- R1: On `rst` or on a `bus_rst` pulse, the following cycle shows `tx_en`=0, `selected`=0 and `func_valid`=0, and the engine waits for a new ROM command with all bit counters cleared. A `bus_rst` arriving in the same cycle as `slot_stb` wins, and that slot is discarded.
- R2: A ROM command is the bits of 8 consecutive slots, taken least significant bit first. Its codes are: 0xF0 search, 0x33 read, 0x55 match, 0xCC skip, 0xEC alarm search. All outputs change on the clock edge that registers the strobe and hold steady between strobes.
- R3: After read (0x33), the next 64 slots have `tx_en`=1. Slot k carries `tx_bit`=`dev_id[k]`, starting from bit 0 (the family code byte is in bits 7:0). After the 64th slot, `selected`=1.
- R4: After match (0x55), 64 received bits are compared with `dev_id`, bit 0 first. If all agree, `selected`=1. On the first disagreement the engine parks: no transmit and `selected`=0 until `bus_rst`.
- R5: After skip (0xCC), `selected`=1 directly after the 8th command slot.
- R6: After search (0xF0), each identity bit k uses three slots. The first transmits `dev_id[k]`, the second transmits its inverse, and the third receives the master's choice. If the choice differs from `dev_id[k]`, the engine parks until `bus_rst`.
- R7: Alarm search (0xEC) behaves as search when `alarm_flag`=1 in the cycle of the 8th command slot. Otherwise the engine parks with `tx_en`=0.
- R8: When all 64 search bits agree, the engine parks with `selected`=0. Later slots have no effect on the outputs until `bus_rst`.
- R9: While selected, the next 8 slots form a function code, least significant bit first. If the code is 0x44, 0x4E, 0xBE, 0x48 or 0xB8, the engine pulses `func_valid` for one cycle with `func_code` holding the code, and keeps `selected`=1. After that, slots are ignored until `bus_rst`.
- R10: An unrecognised ROM or function code parks the engine: `selected`=0 and `tx_en`=0 until `bus_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | One-cycle pulse: bus reset seen by the time-slot engine |
| slot_stb | input | 1 | One-cycle pulse: a bit slot has finished |
| slot_bit | input | 1 | Bit sampled in the finished slot |
| alarm_flag | input | 1 | Alarm condition from the measurement side |
| dev_id | input | ID_W | Device identity, bit 0 sent first |
| tx_en | output | 1 | Engine drives the next slot |
| tx_bit | output | 1 | Bit to drive when `tx_en` is high |
| selected | output | 1 | Device is addressed and owns the function phase |
| func_valid | output | 1 | One-cycle strobe: recognised function code |
| func_code | output | 8 | Last recognised function code |

## Verification
Two events can land in one clock: a bus reset pulse and a slot strobe. The bench provokes this in the middle of a read transfer and again on the 8th bit of a command. It expects the reset to win, with the outputs cleared on the next cycle and a following skip command decoded from a clean bit count. The alarm flag is also moved in the cycle that the alarm-search command completes. Judgement compares the outputs on every clock against a behavioural model that samples the flag at that same edge.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;

  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] ROM_SEARCH = 8'hF0;
  localparam logic [CODE_W-1:0] ROM_READ   = 8'h33;
  localparam logic [CODE_W-1:0] ROM_MATCH  = 8'h55;
  localparam logic [CODE_W-1:0] ROM_SKIP   = 8'hCC;
  localparam logic [CODE_W-1:0] ROM_ALARM  = 8'hEC;

  localparam int N_FUNC = 5;
  localparam logic [N_FUNC*CODE_W-1:0] FUNC_CODES =
    {8'h44, 8'h4E, 8'hBE, 8'h48, 8'hB8};

  typedef enum logic [2:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH,
    ST_FUNC,
    ST_HAND,
    ST_PARK
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_TRUE,
    PH_CMP,
    PH_RX
  } srch_ph_t;

endpackage

// File: rtl/owr_lsb_shift.sv
module owr_lsb_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word_nxt
);
  logic [W-1:0] word_q;

  assign word_nxt = {din, word_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word_q <= '0;
    end else if (shift_en) begin
      word_q <= word_nxt;
    end
  end
endmodule

// File: rtl/owr_id_pick.sv
module owr_id_pick #(
  parameter int ID_W = 64,
  localparam int IW  = $clog2(ID_W)
) (
  input  logic [ID_W-1:0] id,
  input  logic [IW-1:0]   idx,
  output logic            bit_o
);
  assign bit_o = id[idx];
endmodule

// File: rtl/owr_code_match.sv
module owr_code_match #(
  parameter int W = 8,
  parameter int N = 5,
  parameter logic [N*W-1:0] CODES = '0
) (
  input  logic [W-1:0] code,
  output logic         hit
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (code == CODES[g*W +: W]);
  end

  assign hit = |eq;
endmodule

// File: rtl/owr_rom_engine.sv
module owr_rom_engine
  import owr_rom_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_rst,
  input  logic                slot_stb,
  input  logic                slot_bit,
  input  logic                alarm_flag,
  input  logic [ID_W-1:0]     dev_id,
  output logic                tx_en,
  output logic                tx_bit,
  output logic                selected,
  output logic                func_valid,
  output logic [CODE_W-1:0]   func_code
);
  localparam int IW = $clog2(ID_W);
  localparam int CW = $clog2(CODE_W);
  localparam logic [IW-1:0] IDX_LAST = IW'(ID_W - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CODE_W - 1);

  eng_state_t          state, n_state;
  srch_ph_t            ph, n_ph;
  logic [IW-1:0]       idx, n_idx;
  logic [CW-1:0]       cnt, n_cnt;
  logic                n_fv;
  logic [CODE_W-1:0]   n_fc;
  logic                n_tx_en, n_tx_bit, n_sel;
  logic                sh_en;
  logic [CODE_W-1:0]   word_nxt;
  logic                cur_id_bit, nxt_id_bit;
  logic                fn_hit;

  owr_lsb_shift #(.W(CODE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (bus_rst),
    .shift_en (sh_en),
    .din      (slot_bit),
    .word_nxt (word_nxt)
  );

  owr_id_pick #(.ID_W(ID_W)) u_pick_cur (
    .id    (dev_id),
    .idx   (idx),
    .bit_o (cur_id_bit)
  );

  owr_id_pick #(.ID_W(ID_W)) u_pick_nxt (
    .id    (dev_id),
    .idx   (n_idx),
    .bit_o (nxt_id_bit)
  );

  owr_code_match #(.W(CODE_W), .N(N_FUNC), .CODES(FUNC_CODES)) u_fmatch (
    .code (word_nxt),
    .hit  (fn_hit)
  );

  // next-state decision, one step per finished slot
  always_comb begin
    n_state = state;
    n_ph    = ph;
    n_idx   = idx;
    n_cnt   = cnt;
    n_fv    = 1'b0;
    n_fc    = func_code;
    sh_en   = 1'b0;
    if (bus_rst) begin
      n_state = ST_CMD;
      n_ph    = PH_TRUE;
      n_idx   = '0;
      n_cnt   = '0;
    end else if (slot_stb) begin
      unique case (state)
        ST_CMD: begin
          sh_en = 1'b1;
          if (cnt == CNT_LAST) begin
            n_cnt = '0;
            n_idx = '0;
            n_ph  = PH_TRUE;
            case (word_nxt)
              ROM_READ:   n_state = ST_READ;
              ROM_MATCH:  n_state = ST_MATCH;
              ROM_SKIP:   n_state = ST_FUNC;
              ROM_SEARCH: n_state = ST_SRCH;
              ROM_ALARM:  n_state = alarm_flag ? ST_SRCH : ST_PARK;
              default:    n_state = ST_PARK;
            endcase
          end else begin
            n_cnt = cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (idx == IDX_LAST) n_state = ST_FUNC;
          else                 n_idx   = idx + 1'b1;
        end
        ST_MATCH: begin
          if (slot_bit != cur_id_bit) n_state = ST_PARK;
          else if (idx == IDX_LAST)   n_state = ST_FUNC;
          else                        n_idx   = idx + 1'b1;
        end
        ST_SRCH: begin
          unique case (ph)
            PH_TRUE: n_ph = PH_CMP;
            PH_CMP:  n_ph = PH_RX;
            default: begin
              n_ph = PH_TRUE;
              if (slot_bit != cur_id_bit || idx == IDX_LAST) n_state = ST_PARK;
              else                                            n_idx = idx + 1'b1;
            end
          endcase
        end
        ST_FUNC: begin
          sh_en = 1'b1;
          if (cnt == CNT_LAST) begin
            n_cnt = '0;
            if (fn_hit) begin
              n_state = ST_HAND;
              n_fv    = 1'b1;
              n_fc    = word_nxt;
            end else begin
              n_state = ST_PARK;
            end
          end else begin
            n_cnt = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // output values that belong to the next state
  always_comb begin
    n_tx_en  = (n_state == ST_READ) || ((n_state == ST_SRCH) && (n_ph != PH_RX));
    n_tx_bit = n_tx_en && (nxt_id_bit ^ ((n_state == ST_SRCH) && (n_ph == PH_CMP)));
    n_sel    = (n_state == ST_FUNC) || (n_state == ST_HAND);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CMD;
      ph         <= PH_TRUE;
      idx        <= '0;
      cnt        <= '0;
      tx_en      <= 1'b0;
      tx_bit     <= 1'b0;
      selected   <= 1'b0;
      func_valid <= 1'b0;
      func_code  <= '0;
    end else begin
      state      <= n_state;
      ph         <= n_ph;
      idx        <= n_idx;
      cnt        <= n_cnt;
      tx_en      <= n_tx_en;
      tx_bit     <= n_tx_bit;
      selected   <= n_sel;
      func_valid <= n_fv;
      func_code  <= n_fc;
    end
  end
endmodule

// File: rtl/owr_rom_engine_chk.sv
module owr_rom_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_rst,
  input logic       slot_stb,
  input logic       tx_en,
  input logic       tx_bit,
  input logic       selected,
  input logic       func_valid,
  input logic [7:0] func_code
);
  a_r1_bus_reset_clears: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (!tx_en && !selected && !func_valid));

  a_r2_hold_between_slots: assert property (@(posedge clk) disable iff (rst)
    (!slot_stb && !bus_rst) |=> ($stable(tx_en) && $stable(tx_bit) && $stable(selected) && !func_valid));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    func_valid |=> !func_valid);

  a_r9_pulse_while_selected: assert property (@(posedge clk) disable iff (rst)
    func_valid |-> selected);

  a_r10_only_legal_codes: assert property (@(posedge clk) disable iff (rst)
    func_valid |-> (func_code == 8'h44 || func_code == 8'h4E || func_code == 8'hBE ||
                    func_code == 8'h48 || func_code == 8'hB8));

  a_r3_no_tx_when_selected: assert property (@(posedge clk) disable iff (rst)
    selected |-> !tx_en);
endmodule

bind owr_rom_engine owr_rom_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rst    (bus_rst),
  .slot_stb   (slot_stb),
  .tx_en      (tx_en),
  .tx_bit     (tx_bit),
  .selected   (selected),
  .func_valid (func_valid),
  .func_code  (func_code)
);

// File: tb/owr_rom_engine_test.sv
module owr_rom_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_rst = 1'b0;
  logic slot_stb = 1'b0;
  logic slot_bit = 1'b0;
  logic alarm_flag = 1'b0;
  logic [63:0] dev_id = 64'hA2_D7_1B_5C_93_E7_4D_28;
  logic tx_en, tx_bit, selected, func_valid;
  logic [7:0] func_code;

  int vectors = 0;
  int miscomp = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  owr_rom_engine #(.ID_W(64)) uut (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .slot_stb(slot_stb),
    .slot_bit(slot_bit), .alarm_flag(alarm_flag), .dev_id(dev_id),
    .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected),
    .func_valid(func_valid), .func_code(func_code)
  );

  // behavioural reference: m 0 cmd,1 read,2 match,3 search,4 func,5 handed,6 parked
  int m = 0, n = 0, k = 0, ph = 0;
  logic [7:0] rb = '0;
  logic e_txen = 0, e_txbit = 0, e_sel = 0, e_fv = 0;
  logic [7:0] e_fc = '0;

  always @(posedge clk) begin
    e_fv = 1'b0;
    if (rst) e_fc = '0;
    if (rst || bus_rst) begin
      m = 0; n = 0; k = 0; ph = 0;
    end else if (slot_stb) begin
      case (m)
        0: begin
          rb[n] = slot_bit; n = n + 1;
          if (n == 8) begin
            n = 0; k = 0; ph = 0;
            if (rb == 8'h33) m = 1;
            else if (rb == 8'h55) m = 2;
            else if (rb == 8'hCC) m = 4;
            else if (rb == 8'hF0) m = 3;
            else if (rb == 8'hEC) m = alarm_flag ? 3 : 6;
            else m = 6;
          end
        end
        1: if (k == 63) m = 4; else k = k + 1;
        2: if (slot_bit !== dev_id[k]) m = 6; else if (k == 63) m = 4; else k = k + 1;
        3: begin
          if (ph < 2) ph = ph + 1;
          else begin
            ph = 0;
            if (slot_bit !== dev_id[k] || k == 63) m = 6; else k = k + 1;
          end
        end
        4: begin
          rb[n] = slot_bit; n = n + 1;
          if (n == 8) begin
            n = 0;
            if (rb == 8'h44 || rb == 8'h4E || rb == 8'hBE || rb == 8'h48 || rb == 8'hB8) begin
              m = 5; e_fv = 1'b1; e_fc = rb;
            end else m = 6;
          end
        end
        default: ;
      endcase
    end
    e_txen  = (m == 1) || (m == 3 && ph < 2);
    e_txbit = e_txen && ((m == 1 || ph == 0) ? dev_id[k] : !dev_id[k]);
    e_sel   = (m == 4) || (m == 5);
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (tx_en !== e_txen || tx_bit !== e_txbit || selected !== e_sel ||
          func_valid !== e_fv || func_code !== e_fc) begin
        miscomp++;
        $display("FAIL %s cycle compare: got en=%b bit=%b sel=%b fv=%b fc=%h exp en=%b bit=%b sel=%b fv=%b fc=%h",
                 cur_req, tx_en, tx_bit, selected, func_valid, func_code,
                 e_txen, e_txbit, e_sel, e_fv, e_fc);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    @(negedge clk); slot_stb = 1'b1; slot_bit = b;
    @(negedge clk); slot_stb = 1'b0; slot_bit = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) slot(v[i]);
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscomp++;
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk(!tx_en && !selected && !func_valid, "R1", "reset state", {5'd0, tx_en, selected, func_valid}, 8'h00);

    // read ROM then a legal function code
    cur_req = "R3";
    send_byte(8'h33);
    chk(tx_en && tx_bit == dev_id[0], "R3", "first read bit", {7'd0, tx_bit}, {7'd0, dev_id[0]});
    for (int i = 0; i < 64; i++) slot(1'b1);
    chk(selected && !tx_en, "R3", "selected after read", {7'd0, selected}, 8'h01);
    cur_req = "R9";
    send_byte(8'h44);
    chk(func_valid && func_code == 8'h44, "R9", "convert code strobe", func_code, 8'h44);
    send_byte(8'hBE);
    chk(selected && func_code == 8'h44, "R9", "later slots ignored", func_code, 8'h44);

    // skip
    pulse_bus_rst();
    cur_req = "R5";
    send_byte(8'hCC);
    chk(selected, "R5", "selected after skip", {7'd0, selected}, 8'h01);
    send_byte(8'hB8);
    chk(func_valid && func_code == 8'hB8, "R9", "recall code strobe", func_code, 8'hB8);

    // match, correct code, then illegal function
    pulse_bus_rst();
    cur_req = "R4";
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) slot(dev_id[i]);
    chk(selected, "R4", "match accepted", {7'd0, selected}, 8'h01);
    cur_req = "R10";
    send_byte(8'h12);
    chk(!selected && !func_valid, "R10", "illegal function parks", {7'd0, selected}, 8'h00);

    // match with one wrong bit
    pulse_bus_rst();
    cur_req = "R4";
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) slot(i == 20 ? !dev_id[i] : dev_id[i]);
    chk(!selected && !tx_en, "R4", "mismatch parks", {7'd0, selected}, 8'h00);

    // full search
    pulse_bus_rst();
    cur_req = "R6";
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      chk(tx_en && tx_bit == dev_id[i], "R6", "true bit", {7'd0, tx_bit}, {7'd0, dev_id[i]});
      slot(1'b1);
      chk(tx_en && tx_bit == !dev_id[i], "R6", "complement bit", {7'd0, tx_bit}, {7'd0, !dev_id[i]});
      slot(1'b1);
      slot(dev_id[i]);
    end
    cur_req = "R8";
    chk(!selected && !tx_en, "R8", "search end parks", {7'd0, selected}, 8'h00);
    send_byte(8'h44);
    chk(!func_valid && !selected, "R8", "function after search ignored", {7'd0, func_valid}, 8'h00);

    // search losing at bit 5
    pulse_bus_rst();
    cur_req = "R6";
    send_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      slot(1'b1); slot(1'b1); slot(i == 5 ? !dev_id[i] : dev_id[i]);
    end
    chk(!tx_en, "R6", "dropped out on disagreement", {7'd0, tx_en}, 8'h00);
    slot(1'b1);
    chk(!tx_en && !selected, "R6", "stays out", {7'd0, tx_en}, 8'h00);

    // alarm search, flag clear then set (flag moves at the decode edge)
    pulse_bus_rst();
    cur_req = "R7";
    alarm_flag = 1'b0;
    send_byte(8'hEC);
    chk(!tx_en, "R7", "no alarm no reply", {7'd0, tx_en}, 8'h00);
    pulse_bus_rst();
    for (int i = 0; i < 7; i++) slot(i == 2 || i == 3 || i == 5 || i == 6);
    @(negedge clk); slot_stb = 1'b1; slot_bit = 1'b1; alarm_flag = 1'b1;
    @(negedge clk); slot_stb = 1'b0; slot_bit = 1'b0;
    chk(tx_en && tx_bit == dev_id[0], "R7", "alarmed device replies", {7'd0, tx_bit}, {7'd0, dev_id[0]});
    alarm_flag = 1'b0;

    // unknown ROM code
    pulse_bus_rst();
    cur_req = "R10";
    send_byte(8'h99);
    send_byte(8'hCC);
    chk(!selected && !tx_en, "R10", "unknown ROM code parks", {7'd0, selected}, 8'h00);

    // collisions: reset and slot in one cycle
    pulse_bus_rst();
    cur_req = "R1";
    send_byte(8'h33);
    for (int i = 0; i < 10; i++) slot(1'b1);
    @(negedge clk); bus_rst = 1'b1; slot_stb = 1'b1; slot_bit = 1'b1;
    @(negedge clk); bus_rst = 1'b0; slot_stb = 1'b0; slot_bit = 1'b0;
    chk(!tx_en && !selected, "R1", "reset wins over slot", {7'd0, tx_en}, 8'h00);
    for (int i = 0; i < 7; i++) slot(i == 2 || i == 3 || i == 6 || i == 7);
    @(negedge clk); bus_rst = 1'b1; slot_stb = 1'b1; slot_bit = 1'b1;
    @(negedge clk); bus_rst = 1'b0; slot_stb = 1'b0; slot_bit = 1'b0;
    cur_req = "R2";
    send_byte(8'hCC);
    chk(selected, "R2", "fresh count after collision", {7'd0, selected}, 8'h01);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule